// File: doc/BRIEF.md
# Loop Counter Branch Unit

This block carries out the counted-loop branch primitive of a 16-bit processor core. Each operation is described by a control byte and a signed offset byte. The control byte picks a register, a step of minus one, zero or plus one, a branch condition of zero or nonzero, and the sign of the offset. The unit reads the chosen register through a combinational read port and applies the step. It then tests the stepped value and reports whether the branch is taken, along with the target address. It also returns the stepped value for write-back into the register file.

The register codes mix three 8-bit registers with five 16-bit ones. For the narrow registers the step and the zero test cover only the low byte, and the upper byte of the written value is zero. The program counter supplied with each operation already points past the operand bytes. The 9-bit offset is added to it, and the sum wraps at 16 bits. Results are registered and appear one clock after the operation is presented.

Top module: `lcb_unit`

## Requirements
- R1: After a synchronous reset, out_valid, wr_en, taken and illegal are all 0.
- R2: Control bits 7:6 select the step: 00 subtracts one, 01 leaves the value unchanged, 10 adds one. For any legal step, wr_data is the register value read plus the step.
- R3: Control bit 5 selects the condition. When it is 1, taken is 1 exactly when the stepped value is nonzero. When it is 0, taken is 1 exactly when the stepped value is zero. The test is made on the stepped value, not on the value read.
- R4: Control bit 4 gives the offset sign. target equals pc_next plus the offset byte, with its upper byte filled with ones when bit 4 is 1 and with zeros when bit 4 is 0.
- R5: Control bits 2:0 select the register: 0, 1 and 2 are the 8-bit registers, 3 to 7 are 16-bit. rf_rd_sel carries this code in the same cycle, and wr_sel carries it with the result. For codes 0 to 2 the step and the zero test use bits 7:0 only, wr_data[15:8] is 0 and wr_wide is 0. For codes 3 to 7, wr_wide is 1.
- R6: Every legal operation asserts wr_en with its result, whether or not the branch is taken.
- R7: Control bits 7:6 equal to 11 set illegal with the result and force wr_en and taken to 0.
- R8: A result, marked by out_valid, appears exactly one clock after in_valid is sampled high. Without in_valid, out_valid, wr_en, taken and illegal stay 0 in the following cycle.
- R9: The target addition wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| ctl_byte | input | 8 | Loop control byte: step, condition, offset sign, register code |
| ofs_byte | input | 8 | Low byte of the branch offset |
| pc_next | input | 16 | Program counter past all operand bytes |
| rf_rd_sel | output | 3 | Register code driven to the register-file read port |
| rf_rd_data | input | 16 | Register value returned for rf_rd_sel |
| out_valid | output | 1 | Result registers hold a new result |
| wr_en | output | 1 | Write the stepped value back |
| wr_sel | output | 3 | Register code for the write-back |
| wr_data | output | 16 | Stepped value, upper byte zero for 8-bit registers |
| wr_wide | output | 1 | Write-back covers all 16 bits |
| taken | output | 1 | Branch condition met |
| target | output | 16 | Branch target address |
| illegal | output | 1 | Control byte used the reserved step code |

## Verification
The bench sweeps every register code through every step and both conditions. It picks start values that land the stepped result on zero or just off it. The narrow registers are given nonzero upper bytes. A design that stepped or tested all 16 bits of A, B or CCR would then write back a nonzero upper byte and branch the wrong way. A design that tested the value before the step would flip taken whenever the step crosses zero. Offsets are driven with both signs and near both ends of the address space, so a missing sign fill or a lost wrap shows as a wrong target. Reserved step codes are mixed in, so a unit that still wrote back or branched on them is caught.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

    // Step selection carried in control bits 7:6
    typedef enum logic [1:0] {
        STEP_DEC = 2'b00,
        STEP_NONE = 2'b01,
        STEP_INC = 2'b10,
        STEP_RSVD = 2'b11
    } lcb_step_e;

    // Register code carried in control bits 2:0
    typedef enum logic [2:0] {
        RC_ACC_A = 3'd0,
        RC_ACC_B = 3'd1,
        RC_FLAGS = 3'd2,
        RC_SCRATCH = 3'd3,
        RC_ACC_D = 3'd4,
        RC_IDX_X = 3'd5,
        RC_IDX_Y = 3'd6,
        RC_STACK = 3'd7
    } lcb_reg_e;

    typedef struct packed {
        lcb_step_e step;
        logic      on_nonzero;
        logic      ofs_neg;
        lcb_reg_e  sel;
        logic      narrow;
        logic      rsvd;
    } lcb_ctl_t;

    localparam int LCB_CTL_W = 8;

    function automatic logic lcb_is_narrow(input lcb_reg_e r);
        return (r == RC_ACC_A) || (r == RC_ACC_B) || (r == RC_FLAGS);
    endfunction

    function automatic lcb_ctl_t lcb_split(input logic [LCB_CTL_W-1:0] b);
        lcb_ctl_t c;
        c.step       = lcb_step_e'(b[7:6]);
        c.on_nonzero = b[5];
        c.ofs_neg    = b[4];
        c.sel        = lcb_reg_e'(b[2:0]);
        c.narrow     = lcb_is_narrow(c.sel);
        c.rsvd       = (c.step == STEP_RSVD);
        return c;
    endfunction

endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
    import lcb_pkg::*;
(
    input  logic [LCB_CTL_W-1:0] ctl_byte,
    output lcb_ctl_t             ctl
);
    always_comb begin
        ctl = lcb_split(ctl_byte);
    end
endmodule

// File: rtl/lcb_step.sv
module lcb_step
    import lcb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  lcb_ctl_t            ctl,
    input  logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   next_val,
    output logic                cond_met
);
    localparam int PAD_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0]   step_v;
    logic [DATA_W-1:0]   sum_wide;
    logic [NARROW_W-1:0] sum_narrow;
    logic [DATA_W-1:0]   narrow_ext;
    logic                is_zero;

    always_comb begin
        unique case (ctl.step)
            STEP_DEC: step_v = '1;
            STEP_INC: step_v = {{(DATA_W-1){1'b0}}, 1'b1};
            default:  step_v = '0;
        endcase
    end

    assign sum_wide   = rd_data + step_v;
    assign sum_narrow = rd_data[NARROW_W-1:0] + step_v[NARROW_W-1:0];

    generate
        if (PAD_W > 0) begin : g_pad
            assign narrow_ext = {{PAD_W{1'b0}}, sum_narrow};
        end else begin : g_nopad
            assign narrow_ext = sum_narrow;
        end
    endgenerate

    always_comb begin
        next_val = ctl.narrow ? narrow_ext : sum_wide;
        is_zero  = (next_val == '0);
        cond_met = ctl.on_nonzero ? !is_zero : is_zero;
    end
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] pc_next,
    input  logic [OFS_W-1:0]  ofs_byte,
    input  logic              ofs_neg,
    output logic [ADDR_W-1:0] target
);
    localparam int FILL_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    assign ofs_ext = {{FILL_W{ofs_neg}}, ofs_byte};
    assign target  = pc_next + ofs_ext;
endmodule

// File: rtl/lcb_unit.sv
module lcb_unit
    import lcb_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8,
    parameter int ADDR_W   = 16,
    parameter int OFS_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        ctl_byte,
    input  logic [OFS_W-1:0]  ofs_byte,
    input  logic [ADDR_W-1:0] pc_next,
    output logic [2:0]        rf_rd_sel,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              out_valid,
    output logic              wr_en,
    output logic [2:0]        wr_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_wide,
    output logic              taken,
    output logic [ADDR_W-1:0] target,
    output logic              illegal
);
    lcb_ctl_t          ctl;
    logic [DATA_W-1:0] next_val;
    logic              cond_met;
    logic [ADDR_W-1:0] tgt_c;

    lcb_decode u_dec (
        .ctl_byte (ctl_byte),
        .ctl      (ctl)
    );

    lcb_step #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_step (
        .ctl      (ctl),
        .rd_data  (rf_rd_data),
        .next_val (next_val),
        .cond_met (cond_met)
    );

    lcb_target #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_tgt (
        .pc_next  (pc_next),
        .ofs_byte (ofs_byte),
        .ofs_neg  (ctl.ofs_neg),
        .target   (tgt_c)
    );

    assign rf_rd_sel = ctl.sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_sel    <= '0;
            wr_data   <= '0;
            wr_wide   <= 1'b0;
            taken     <= 1'b0;
            target    <= '0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && !ctl.rsvd;
            taken     <= in_valid && !ctl.rsvd && cond_met;
            illegal   <= in_valid && ctl.rsvd;
            if (in_valid) begin
                wr_sel  <= ctl.sel;
                wr_data <= next_val;
                wr_wide <= !ctl.narrow;
                target  <= tgt_c;
            end
        end
    end
endmodule

// File: rtl/lcb_unit_chk.sv
module lcb_unit_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        ctl_byte,
    input logic [2:0]        rf_rd_sel,
    input logic              out_valid,
    input logic              wr_en,
    input logic [2:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_wide,
    input logic              taken,
    input logic              illegal
);
    // R8: a result follows every accepted operation
    a_r8_result_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8: nothing is reported without a preceding operation
    a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !wr_en && !taken && !illegal));

    // R7: a reserved step code never writes or branches
    a_r7_rsvd_inert: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_byte[7:6] == 2'b11) |=> (illegal && !wr_en && !taken));

    // R6: every legal result writes back
    a_r6_always_write: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal) |-> wr_en);

    // R5: write-back targets the register that was read
    a_r5_same_reg: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (wr_sel == $past(rf_rd_sel)));

    // R5: narrow registers write back a zero upper byte
    a_r5_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel < 3'd3) |-> (wr_data[DATA_W-1:8] == '0 && !wr_wide));

    // R3: branch decision agrees with the stepped value and the condition bit
    a_r3_condition: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_byte[7:6] != 2'b11) |=>
            (taken == ($past(ctl_byte[5]) ? (wr_data != '0) : (wr_data == '0))));
endmodule

bind lcb_unit lcb_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .ctl_byte  (ctl_byte),
    .rf_rd_sel (rf_rd_sel),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .wr_wide   (wr_wide),
    .taken     (taken),
    .illegal   (illegal)
);

// File: tb/lcb_unit_tb.sv
module lcb_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  ctl_byte;
    logic [7:0]  ofs_byte;
    logic [15:0] pc_next;
    logic [2:0]  rf_rd_sel;
    logic [15:0] rf_rd_data;
    logic        out_valid, wr_en, wr_wide, taken, illegal;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data, target;

    logic [15:0] regs [8];

    typedef struct {
        logic        wr_en;
        logic [2:0]  sel;
        logic [15:0] data;
        logic        wide;
        logic        taken;
        logic [15:0] target;
        logic        illegal;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    assign rf_rd_data = regs[rf_rd_sel];

    lcb_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ctl_byte(ctl_byte),
        .ofs_byte(ofs_byte), .pc_next(pc_next), .rf_rd_sel(rf_rd_sel),
        .rf_rd_data(rf_rd_data), .out_valid(out_valid), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .wr_wide(wr_wide), .taken(taken),
        .target(target), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one operation and pushes its expected result
    task automatic issue(input logic [7:0] cb, input logic [7:0] ob,
                         input logic [15:0] pc, input logic [15:0] val,
                         input string tag);
        exp_t e;
        logic        narrow;
        logic [15:0] stepped, step;
        regs[cb[2:0]] = val;
        ctl_byte = cb; ofs_byte = ob; pc_next = pc; in_valid = 1'b1;
        narrow = (cb[2:0] < 3'd3);
        step = (cb[7:6] == 2'b00) ? 16'hFFFF : (cb[7:6] == 2'b10) ? 16'h0001 : 16'h0000;
        stepped = val + step;
        if (narrow) stepped = {8'h00, stepped[7:0]};
        e.illegal = (cb[7:6] == 2'b11);
        e.wr_en   = !e.illegal;
        e.sel     = cb[2:0];
        e.data    = stepped;
        e.wide    = !narrow;
        e.taken   = !e.illegal && (cb[5] ? (stepped != 0) : (stepped == 0));
        e.target  = pc + {(cb[4] ? 8'hFF : 8'h00), ob};
        e.tag     = tag;
        sb.push_back(e);
        #1;
        chk(rf_rd_sel == cb[2:0], "R5 rd_sel", {13'd0, rf_rd_sel}, {13'd0, cb[2:0]});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops and compares results as they appear
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R8 unexpected result", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(illegal == e.illegal, {"R7 illegal ", e.tag}, {15'd0, illegal}, {15'd0, e.illegal});
                chk(wr_en == e.wr_en, {"R6 wr_en ", e.tag}, {15'd0, wr_en}, {15'd0, e.wr_en});
                chk(taken == e.taken, {"R3 taken ", e.tag}, {15'd0, taken}, {15'd0, e.taken});
                chk(target == e.target, {"R4 target ", e.tag}, target, e.target);
                if (!e.illegal) begin
                    chk(wr_sel == e.sel, {"R5 wr_sel ", e.tag}, {13'd0, wr_sel}, {13'd0, e.sel});
                    chk(wr_wide == e.wide, {"R5 wr_wide ", e.tag}, {15'd0, wr_wide}, {15'd0, e.wide});
                    chk(wr_data == e.data, {"R2 wr_data ", e.tag}, wr_data, e.data);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            chk(0, "watchdog", 16'd0, 16'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 16'h0000;
        rst = 1'b1; in_valid = 1'b0; ctl_byte = 8'h00; ofs_byte = 8'h00; pc_next = 16'h0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && !wr_en && !taken && !illegal, "R1 reset outputs",
            {12'd0, out_valid, wr_en, taken, illegal}, 16'd0);

        // R2/R3/R5/R6: every register, step and condition, landing on and off zero
        for (int c = 0; c < 8; c++) begin
            for (int op = 0; op < 3; op++) begin
                for (int cond = 0; cond < 2; cond++) begin
                    logic [15:0] hit, miss;
                    logic [7:0]  cb;
                    cb = {op[1:0], cond[0], 1'b0, 1'b0, c[2:0]};
                    if (c < 3) begin
                        hit  = (op == 0) ? 16'h5A01 : (op == 2) ? 16'h33FF : 16'h7700;
                        miss = (op == 0) ? 16'h0000 : (op == 2) ? 16'h0080 : 16'h0042;
                    end else begin
                        hit  = (op == 0) ? 16'h0001 : (op == 2) ? 16'hFFFF : 16'h0000;
                        miss = (op == 0) ? 16'h0100 : (op == 2) ? 16'h00FF : 16'h8000;
                    end
                    issue(cb, 8'h10, 16'h4000, hit,  "R2 R3 R5 zero result");
                    issue(cb, 8'h22, 16'h4000, miss, "R2 R3 R5 nonzero result");
                end
            end
        end

        // R3: test is on the stepped value (1 decremented is zero, value read is not)
        issue(8'b0010_0101, 8'h04, 16'h1000, 16'h0001, "R3 after step");
        issue(8'b1000_0110, 8'h04, 16'h1000, 16'hFFFF, "R3 inc to zero");

        // R4: offset sign from bit 4
        issue(8'b0011_0100, 8'hF0, 16'h2000, 16'h0005, "R4 negative offset");
        issue(8'b0010_0100, 8'hF0, 16'h2000, 16'h0005, "R4 positive F0");
        issue(8'b0011_0100, 8'h00, 16'h2000, 16'h0005, "R4 negative 0x100");

        // R9: wrap in both directions
        issue(8'b0110_0101, 8'h20, 16'hFFF0, 16'h0001, "R9 wrap up");
        issue(8'b0111_0101, 8'hF0, 16'h0005, 16'h0001, "R9 wrap down");

        // R7: reserved step code with both conditions
        issue(8'b1100_0100, 8'h08, 16'h3000, 16'h0001, "R7 reserved");
        issue(8'b1110_0001, 8'h08, 16'h3000, 16'h0000, "R7 reserved cond1");

        // R8: idle cycles report nothing
        @(negedge clk);
        @(negedge clk);
        chk(!out_valid && !wr_en && !taken && !illegal, "R8 idle outputs",
            {12'd0, out_valid, wr_en, taken, illegal}, 16'd0);
        chk(sb.size() == 0, "R8 results drained", 16'(sb.size()), 16'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule